// File: doc/BRIEF.md
# Interleaved Carrier Delay Chain

This block takes a single carrier waveform, delivered one sample per strobe by an upstream generator, and produces a set of interleaved copies of it. Every copy after the first passes through one more delay stage, and each stage delays its input by a programmable number of valid samples. Setting that number to the carrier period divided by the carrier count spreads the copies evenly across one period. For example, six copies of a carrier with a 3600-sample period need a step of 600 samples. The copies then feed per-phase PWM comparators.

Each stage keeps its history in a circular RAM of `MAX_DEPTH` words. The read tap sits exactly the programmed number of samples behind the write pointer, so a stage adds no latency of its own beyond that step. When the required step is longer than the RAM, the system lowers its sample strobe rate so that the step, counted in samples, fits. A stage outputs zero and keeps its ready flag low until it has stored enough history for its current step. Changing the step restarts that wait.

Top module: `cil_carrier_interleaver`

## Requirements
- R1: On each clock edge where `smp_vld_i` is high, carrier 0 takes `smp_i`, all carriers and ready flags update together, and `car_vld_o` is high for the following cycle. With no strobe, `car_vld_o` is low.
- R2: Counting strobes since the step last changed, carrier k (bits `k*DATA_W +: DATA_W` of `car_o`) for sample t equals the master sample t−k·d once it is ready, where d is the step. No extra cycle is added per stage.
- R3: Between strobes, `car_o` and `primed_o` hold their values. Cycles without a strobe do not count toward the delay.
- R4: Stage k (flag bit k−1 of `primed_o`, driving carrier k) reports ready and passes delayed data only after it has received at least d samples since the step took effect. Until then it outputs zero with its flag low.
- R5: A new value on `step_depth_i` takes effect at the next strobe. For that sample, every stage restarts its history count from zero.
- R6: A step of 0 makes every stage a pass-through that is ready at once, so all carriers equal the current sample.
- R7: Any step above `MAX_DEPTH` is treated as `MAX_DEPTH`. A step of exactly `MAX_DEPTH` is supported.
- R8: After synchronous active-low reset, `car_o` is zero, `primed_o` is zero and `car_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld_i | input | 1 | Master sample strobe |
| smp_i | input | DATA_W | Master carrier sample |
| step_depth_i | input | clog2(MAX_DEPTH)+1 | Per-stage delay in samples |
| car_o | output | N_CAR*DATA_W | Interleaved carriers, carrier k at bits k*DATA_W |
| car_vld_o | output | 1 | High the cycle after carriers update |
| primed_o | output | N_CAR-1 | Ready flag per delay stage |

## Verification
Every result is due on the first rising edge after the strobe that produced it, because one output register lies between the strobe and the ports. The monitor therefore reads the ports on the falling edge after that rising edge, but only when `car_vld_o` is high, and compares them with the oldest queued expectation. Delayed data is due d strobes later, not d cycles, so the reference model counts strobes. Inserted idle gaps confirm that the delay count does not advance during them. On every falling edge without `car_vld_o`, the monitor compares the ports with the previous result to check that they held.

// File: rtl/cil_pkg.sv
// Shared helpers for the carrier interleaver.
// Assumes widths of 32 bits or less for depth arithmetic.
package cil_pkg;
    // Saturate a requested delay at the buffer capacity.
    function automatic logic [31:0] cap_depth(input logic [31:0] req, input logic [31:0] max_d);
        return (req > max_d) ? max_d : req;
    endfunction
endpackage

// File: rtl/cil_ring_ram.sv
// Circular sample store: one write port and one asynchronous read port.
// A read of the address being written returns the old word, which is
// what gives a delay equal to the full capacity.
// Assumes the contents are not reset; users gate reads until written.
module cil_ring_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [WORDS];

    // Store one sample per write enable.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    // Tap read with no added clock.
    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cil_delay_stage.sv
// One interleave stage: delays its input by depth_i valid samples.
// tap_o is the value registered into dout_o on this strobe, so stages
// chain through tap_o with no extra cycle per stage.
// Assumes depth_i is already limited to MAX_DEPTH.
module cil_delay_stage #(
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 1024,
    localparam int ADDR_W   = $clog2(MAX_DEPTH),
    localparam int DEPTH_W  = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic [DATA_W-1:0]  din_i,
    output logic [DATA_W-1:0]  tap_o,
    output logic [DATA_W-1:0]  dout_o,
    output logic               primed_o
);
    logic [ADDR_W-1:0]  wr_ptr;
    logic [ADDR_W-1:0]  rd_ptr;
    logic [DEPTH_W-1:0] dep_q;
    logic [DEPTH_W-1:0] fill_q;
    logic [DEPTH_W-1:0] fill_eff;
    logic               ready;
    logic [DATA_W-1:0]  ram_rd;

    // A step change restarts the history count on this sample.
    assign fill_eff = (depth_i != dep_q) ? '0 : fill_q;
    assign ready    = (fill_eff >= depth_i);
    assign rd_ptr   = wr_ptr - depth_i[ADDR_W-1:0];

    // Choose pass-through, delayed word or zero while filling.
    always_comb begin
        if (depth_i == '0)  tap_o = din_i;
        else if (ready)     tap_o = ram_rd;
        else                tap_o = '0;
    end

    cil_ring_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ram (
        .clk     (clk),
        .we_i    (vld_i),
        .waddr_i (wr_ptr),
        .wdata_i (din_i),
        .raddr_i (rd_ptr),
        .rdata_o (ram_rd)
    );

    // Advance pointers and fill count, and register the output, on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            dep_q    <= '0;
            fill_q   <= '0;
            dout_o   <= '0;
            primed_o <= 1'b0;
        end else if (vld_i) begin
            wr_ptr   <= wr_ptr + 1'b1;
            dep_q    <= depth_i;
            fill_q   <= ready ? fill_eff : fill_eff + 1'b1;
            dout_o   <= tap_o;
            primed_o <= ready;
        end
    end

    assert_zero_unprimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_o |-> dout_o == '0);
    assert_change_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && depth_i != dep_q && depth_i != '0) |=> !primed_o);
    assert_zero_step_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && depth_i == '0) |=> (primed_o && dout_o == $past(din_i)));
endmodule

// File: rtl/cil_carrier_interleaver.sv
// Builds N_CAR interleaved carriers from one master sample stream by
// chaining N_CAR-1 programmable RAM delay stages.
// Assumes MAX_DEPTH is a power of two and N_CAR >= 2.
module cil_carrier_interleaver #(
    parameter int N_CAR     = 4,
    parameter int DATA_W    = 16,
    parameter int MAX_DEPTH = 1024,
    localparam int ADDR_W   = $clog2(MAX_DEPTH),
    localparam int DEPTH_W  = ADDR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld_i,
    input  logic [DATA_W-1:0]       smp_i,
    input  logic [DEPTH_W-1:0]      step_depth_i,
    output logic [N_CAR*DATA_W-1:0] car_o,
    output logic                    car_vld_o,
    output logic [N_CAR-2:0]        primed_o
);
    logic [DEPTH_W-1:0] depth_cap;
    logic [DATA_W-1:0]  link [N_CAR];
    logic [DATA_W-1:0]  car0_q;

    // Saturate the requested step at the buffer capacity.
    assign depth_cap = DEPTH_W'(cil_pkg::cap_depth(32'(step_depth_i), 32'(MAX_DEPTH)));
    assign link[0]   = smp_i;

    // Carrier 0 and the update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car0_q    <= '0;
            car_vld_o <= 1'b0;
        end else begin
            car_vld_o <= smp_vld_i;
            if (smp_vld_i) car0_q <= smp_i;
        end
    end
    assign car_o[DATA_W-1:0] = car0_q;

    for (genvar k = 1; k < N_CAR; k++) begin : g_stage
        cil_delay_stage #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) i_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .vld_i    (smp_vld_i),
            .depth_i  (depth_cap),
            .din_i    (link[k-1]),
            .tap_o    (link[k]),
            .dout_o   (car_o[k*DATA_W +: DATA_W]),
            .primed_o (primed_o[k-1])
        );
    end

    assert_vld_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld_i |=> car_vld_o);
    assert_vld_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> !car_vld_o);
    assert_car0_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld_i |=> car_o[DATA_W-1:0] == $past(smp_i));
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> ($stable(car_o) && $stable(primed_o)));
endmodule

// File: tb/test_cil_carrier_interleaver.sv
module test_cil_carrier_interleaver;
    localparam int N_CAR     = 4;
    localparam int DATA_W    = 16;
    localparam int MAX_DEPTH = 1024;
    localparam int DEPTH_W   = $clog2(MAX_DEPTH) + 1;

    typedef struct packed {
        logic [N_CAR*DATA_W-1:0] car;
        logic [N_CAR-2:0]        pr;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_vld_i = 1'b0;
    logic [DATA_W-1:0]       smp_i = '0;
    logic [DEPTH_W-1:0]      step_depth_i = '0;
    logic [N_CAR*DATA_W-1:0] car_o;
    logic                    car_vld_o;
    logic [N_CAR-2:0]        primed_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string tag = "R2";
    exp_t  sb [$];
    int    hist [N_CAR][$];
    int    m_dep = 0;
    exp_t  last;
    bit    have_last = 0;
    int    cyc = 0;

    always #2 clk = ~clk;

    cil_carrier_interleaver #(.N_CAR(N_CAR), .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH)) i_cil_carrier_interleaver (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
        .step_depth_i(step_depth_i), .car_o(car_o), .car_vld_o(car_vld_o), .primed_o(primed_o)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            finish_run();
        end
    end

    // Driver: apply one strobe and queue what the ports must show afterwards.
    task automatic push_sample(input int val, input int dep);
        exp_t e;
        int   d;
        int   x;
        int   y;
        bit   p;
        @(negedge clk);
        smp_vld_i    = 1'b1;
        smp_i        = DATA_W'(val);
        step_depth_i = DEPTH_W'(dep);
        d = (dep > MAX_DEPTH) ? MAX_DEPTH : dep;
        if (d != m_dep) begin
            for (int k = 0; k < N_CAR; k++) hist[k].delete();
            m_dep = d;
        end
        x = val & ((1 << DATA_W) - 1);
        e.car = '0;
        e.pr  = '0;
        e.car[DATA_W-1:0] = DATA_W'(x);
        for (int k = 1; k < N_CAR; k++) begin
            if (d == 0) begin
                y = x; p = 1'b1;
            end else if (hist[k].size() >= d) begin
                y = hist[k][hist[k].size() - d]; p = 1'b1;
            end else begin
                y = 0; p = 1'b0;
            end
            hist[k].push_back(x);
            if (hist[k].size() > MAX_DEPTH + 4) void'(hist[k].pop_front());
            e.car[k*DATA_W +: DATA_W] = DATA_W'(y);
            e.pr[k-1] = p;
            x = y;
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_vld_i = 1'b0;
            smp_i     = 16'hDEAD;
        end
    endtask

    // Monitor: compare each result the cycle after its strobe; otherwise check that outputs hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (car_vld_o) begin
                if (sb.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R1: unexpected result, actual car_vld_o=1 expected 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    for (int k = 0; k < N_CAR; k++) begin
                        n_checks++;
                        if (car_o[k*DATA_W +: DATA_W] !== e.car[k*DATA_W +: DATA_W]) begin
                            n_fail++;
                            $display("FAIL %s carrier%0d: actual %0d expected %0d",
                                     (k == 0) ? "R1" : tag, k,
                                     car_o[k*DATA_W +: DATA_W], e.car[k*DATA_W +: DATA_W]);
                        end
                    end
                    n_checks++;
                    if (primed_o !== e.pr) begin
                        n_fail++;
                        $display("FAIL R4 (%s) primed: actual %b expected %b", tag, primed_o, e.pr);
                    end
                    last = e;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                n_checks++;
                if (car_o !== last.car || primed_o !== last.pr) begin
                    n_fail++;
                    $display("FAIL R3 hold: actual %h/%b expected %h/%b", car_o, primed_o, last.car, last.pr);
                end
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state
        n_checks++;
        if (car_o !== '0 || primed_o !== '0 || car_vld_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset: actual %h/%b/%b expected 0/0/0", car_o, primed_o, car_vld_o);
        end
        rst_n = 1'b1;

        // R2: continuous triangle carrier, step 10 (period 40, four carriers)
        tag = "R2";
        for (int i = 0; i < 120; i++) begin
            int ph;
            ph = i % 40;
            push_sample((ph < 20) ? ph * 100 : (40 - ph) * 100, 10);
        end

        // R3: strobes separated by idle gaps that must not count
        tag = "R3";
        for (int i = 0; i < 40; i++) begin
            push_sample(i * 37 + 5, 10);
            idle(1 + (i % 3));
        end

        // R5: step changes restart priming
        tag = "R5";
        for (int i = 0; i < 40; i++) push_sample(i * 91 + 3, 7);
        for (int i = 0; i < 25; i++) push_sample(i * 13 + 1000, 3);

        // R6: zero step is pass-through
        tag = "R6";
        for (int i = 0; i < 10; i++) push_sample(i * 511 + 7, 0);

        // R7: full-capacity step, an over-range request that saturates, then a clamped restart
        tag = "R7";
        for (int i = 0; i < 3200; i++) push_sample(i * 29 + 11, MAX_DEPTH);
        for (int i = 0; i < 50; i++) push_sample(i * 3 + 60000, 2000);
        for (int i = 0; i < 10; i++) push_sample(i + 400, 5);
        for (int i = 0; i < 1100; i++) push_sample(i * 7 + 2, 1500);

        idle(4);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1 results missing: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule